// File: doc/BRIEF.md
# Quad-I/O Serial Flash Read Responder

This block is the device end of a serial flash read port. The host drives chip select, a serial clock and four data lines. The block oversamples these pins on its own system clock. It decodes a one-bit-wide opcode and then accepts a quad-I/O fast read. In that read the address, the eight mode bits and the dummy clocks each arrive four bits per serial clock. After the last dummy clock the block takes over the data lines and streams bytes from a small internal array, high nibble first.

The block has two features for cache-line fills. The first is a continuous-read state, entered through the mode bits, in which the next access has no opcode phase and begins directly with the address. The second is a burst-wrap setting, loaded by a separate configuration command. When wrap is enabled, the read address stays inside an aligned 8-, 16-, 32- or 64-byte section, so the critical byte comes first and the rest of the line follows. Raising chip select ends any access at once.

Top module: `qspi_read_slave`

## Requirements
- R1: After reset the data-line enable is low, continuous-read is off and wrap is disabled, so a read runs linearly across section boundaries.
- R2: With continuous-read off, the first 8 serial clocks carry an opcode on data line 0, most significant bit first. 0xEB starts a quad read and 0x77 starts the wrap configuration.
- R3: The address arrives one nibble per serial clock, line 3 carrying the most significant bit of each nibble. It takes 6 clocks when `addr32_mode` is 0 and 8 clocks when it is 1. The low log2(MEM_BYTES) bits select the array byte.
- R4: Two clocks of mode bits (M7-4 first) and four dummy clocks follow the address. From the falling edge after the last dummy clock, the enable is high and each byte is driven over two clocks, bits 7-4 then bits 3-0. Outputs change only after falling serial-clock edges.
- R5: Array byte i holds i[7:0] XOR FILL, where FILL defaults to 0x5A.
- R6: With wrap disabled, the address increments by one per byte and rolls over from the last array byte to byte 0.
- R7: When an access completes its mode bits with M5-4 = 2'b10, continuous-read turns on, and the next access starts with the address. Any other value turns it off. An access aborted before its mode bits leaves the state unchanged.
- R8: The 0x77 command is followed by 8 quad clocks, and the wrap byte W7-0 is taken from the last two of them. W4 = 0 enables wrap. W6-5 = 00, 01, 10 and 11 select sections of 8, 16, 32 and 64 bytes.
- R9: With wrap enabled, the address increments inside its aligned section and returns from the section end to the section start, until chip select rises.
- R10: Raising chip select in any phase returns the block to idle and drops the enable within 3 system clocks.
- R11: Any opcode other than 0xEB or 0x77 is ignored: the enable stays low until chip select rises, and the wrap setting is unchanged.
- R12: The serial clock may idle low or high (SPI modes 0 and 3). Data is taken on rising edges in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| addr32_mode | input | 1 | 1 selects 32-bit addresses, 0 selects 24-bit addresses |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_io_in | input | 4 | Data lines as seen at the pins |
| spi_io_out | output | 4 | Nibble driven onto the data lines |
| spi_io_oe | output | 1 | Drive enable for the data lines |

## Verification
The assertions assume that each serial-clock half period lasts at least three system clocks and that chip select never toggles within a few system clocks of a serial-clock edge. Under those conditions every pin edge is seen once and the output pointer advances only at detected falling edges. They also assume that `addr32_mode` and the data lines are stable around each rising edge. The bench holds each serial-clock level for six system clocks, changes data only while the clock is low, and leaves several clocks of margin around every chip-select edge.

// File: rtl/qspi_rd_pkg.sv
// Package: shared phase encoding, command codes and the wrap-section helper
// for the quad read responder.
package qspi_rd_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPC,
        PH_ADDR,
        PH_MODE,
        PH_DUMMY,
        PH_DATA,
        PH_WCFG,
        PH_SKIP
    } phase_t;

    localparam logic [7:0] OP_QREAD   = 8'hEB;
    localparam logic [7:0] OP_SETWRAP = 8'h77;

    // Offset mask of a wrap section: code 0..3 gives 8..64 bytes.
    function automatic logic [6:0] wrap_mask(input logic [1:0] code);
        logic [7:0] len;
        len = 8'd8 << code;
        return 7'(len - 8'd1);
    endfunction

endpackage

// File: rtl/qspi_pin_sync.sv
// Module: qspi_pin_sync
// Brings the serial pins into the system clock domain and produces one-cycle
// edge strobes. Assumes that each serial-clock level lasts at least three
// system clocks. The data lines pass through the same number of stages as the
// clock, so a rising strobe always meets the nibble that was set up before it.
module qspi_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_pin,
    input  logic       cs_n_pin,
    input  logic [3:0] io_pin,
    output logic       sck_rise,
    output logic       sck_fall,
    output logic       cs_act,
    output logic       cs_start,
    output logic [3:0] io_s
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sck_sh;
    logic [SYNC_STAGES-1:0] csn_sh;
    logic [3:0]             io_sh [SYNC_STAGES];
    logic                   sck_prev;
    logic                   cs_prev;

    // Synchronizer chains for clock and select; the idle state is clock low, deselected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_sh   <= '0;
            csn_sh   <= '1;
            sck_prev <= 1'b0;
            cs_prev  <= 1'b0;
        end else begin
            sck_sh   <= {sck_sh[SYNC_STAGES-2:0], sck_pin};
            csn_sh   <= {csn_sh[SYNC_STAGES-2:0], cs_n_pin};
            sck_prev <= sck_sh[LAST];
            cs_prev  <= !csn_sh[LAST];
        end
    end

    // Data-line chain of the same depth as the clock chain.
    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_io
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    io_sh[g] <= '0;
                end else begin
                    io_sh[g] <= (g == 0) ? io_pin : io_sh[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    // Edge strobes derived from the last synchronized stage.
    always_comb begin
        cs_act   = !csn_sh[LAST];
        cs_start = cs_act && !cs_prev;
        sck_rise = sck_sh[LAST] && !sck_prev;
        sck_fall = !sck_sh[LAST] && sck_prev;
        io_s     = io_sh[LAST];
    end

endmodule

// File: rtl/qspi_cmd_fsm.sv
// Module: qspi_cmd_fsm
// Command sequencer. It decodes the opcode, collects the address, mode bits
// and wrap byte, counts the dummy clocks, and holds the continuous-read and
// wrap state between accesses. Assumes the edge strobes of qspi_pin_sync and
// acts only while chip select is active.
module qspi_cmd_fsm
    import qspi_rd_pkg::*;
#(
    parameter int PTR_W      = 8,
    parameter int DUMMY_CLKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_act,
    input  logic             cs_start,
    input  logic             sck_rise,
    input  logic [3:0]       io_s,
    input  logic             addr32_mode,
    output phase_t           phase,
    output logic [PTR_W-1:0] addr_q,
    output logic             cont_mode,
    output logic             wrap_en,
    output logic [1:0]       wrap_code
);

    localparam int CNT_W = 4;
    localparam logic [CNT_W-1:0] LAST_DUMMY = CNT_W'(DUMMY_CLKS - 1);

    logic [CNT_W-1:0] cnt;
    logic [31:0]      sh;
    logic [31:0]      sh_quad;
    logic [7:0]       op_nxt;
    logic [CNT_W-1:0] last_addr;

    // Next shift values for quad and single-line capture.
    always_comb begin
        sh_quad   = {sh[27:0], io_s};
        op_nxt    = {sh[6:0], io_s[0]};
        last_addr = addr32_mode ? CNT_W'(7) : CNT_W'(5);
    end

    // Phase sequencing and field capture on rising serial-clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            sh        <= '0;
            addr_q    <= '0;
            cont_mode <= 1'b0;
            wrap_en   <= 1'b0;
            wrap_code <= 2'b00;
        end else if (!cs_act) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (cs_start) begin
            phase <= cont_mode ? PH_ADDR : PH_OPC;
            cnt   <= '0;
            sh    <= '0;
        end else if (sck_rise) begin
            case (phase)
                PH_OPC: begin
                    sh <= {sh[30:0], io_s[0]};
                    if (cnt == CNT_W'(7)) begin
                        cnt <= '0;
                        if (op_nxt == OP_QREAD) begin
                            phase <= PH_ADDR;
                        end else if (op_nxt == OP_SETWRAP) begin
                            phase <= PH_WCFG;
                        end else begin
                            phase <= PH_SKIP;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_ADDR: begin
                    sh <= sh_quad;
                    if (cnt == last_addr) begin
                        cnt    <= '0;
                        addr_q <= sh_quad[PTR_W-1:0];
                        phase  <= PH_MODE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_MODE: begin
                    sh <= sh_quad;
                    if (cnt == CNT_W'(1)) begin
                        cnt       <= '0;
                        cont_mode <= (sh_quad[5:4] == 2'b10);
                        phase     <= PH_DUMMY;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_DUMMY: begin
                    if (cnt == LAST_DUMMY) begin
                        cnt   <= '0;
                        phase <= PH_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_WCFG: begin
                    sh <= sh_quad;
                    if (cnt == CNT_W'(7)) begin
                        cnt       <= '0;
                        wrap_en   <= !sh_quad[4];
                        wrap_code <= sh_quad[6:5];
                        phase     <= PH_SKIP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    cnt <= cnt;
                end
            endcase
        end
    end

endmodule

// File: rtl/qspi_read_path.sv
// Module: qspi_read_path
// Read data path. It holds the byte array and the read pointer, computes the
// linear or wrapped next address, and drives nibbles after falling serial-clock
// edges. Assumes MEM_BYTES is a power of two of at least 64. The array is
// loaded with its fixed pattern at reset.
module qspi_read_path
    import qspi_rd_pkg::*;
#(
    parameter int         MEM_BYTES = 256,
    parameter logic [7:0] FILL      = 8'h5A,
    parameter int         PTR_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_act,
    input  logic             sck_fall,
    input  phase_t           phase,
    input  logic [PTR_W-1:0] addr_q,
    input  logic             wrap_en,
    input  logic [1:0]       wrap_code,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [3:0]       io_out,
    output logic             io_oe
);

    logic [7:0]       mem [MEM_BYTES];
    logic             nib_lo;
    logic [PTR_W-1:0] sec_mask;
    logic [PTR_W-1:0] ptr_inc;
    logic [PTR_W-1:0] ptr_nxt;
    logic [7:0]       cur_byte;
    logic             in_data;

    // Array initialisation with the address-derived pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) begin
                mem[i] <= 8'(i) ^ FILL;
            end
        end
    end

    // Next-address selection: whole-array rollover or aligned section wrap.
    always_comb begin
        in_data  = (phase == PH_DATA);
        sec_mask = PTR_W'(wrap_mask(wrap_code));
        ptr_inc  = rd_ptr + 1'b1;
        ptr_nxt  = wrap_en ? ((rd_ptr & ~sec_mask) | (ptr_inc & sec_mask)) : ptr_inc;
        cur_byte = mem[rd_ptr];
    end

    // Pointer tracking and nibble output on falling edges during the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            nib_lo <= 1'b0;
            io_out <= '0;
            io_oe  <= 1'b0;
        end else if (!cs_act) begin
            nib_lo <= 1'b0;
            io_oe  <= 1'b0;
        end else if (!in_data) begin
            rd_ptr <= addr_q;
            nib_lo <= 1'b0;
        end else if (sck_fall) begin
            io_oe <= 1'b1;
            if (!nib_lo) begin
                io_out <= cur_byte[7:4];
                nib_lo <= 1'b1;
            end else begin
                io_out <= cur_byte[3:0];
                nib_lo <= 1'b0;
                rd_ptr <= ptr_nxt;
            end
        end
    end

endmodule

// File: rtl/qspi_read_slave.sv
// Module: qspi_read_slave
// Top level of the quad-I/O serial flash read responder. Pins are
// oversampled on clk. The command sequencer and the read path share the phase
// and address. Assumes the host keeps each serial-clock level for at least
// three system clocks.
module qspi_read_slave
    import qspi_rd_pkg::*;
#(
    parameter int         MEM_BYTES  = 256,
    parameter logic [7:0] FILL       = 8'h5A,
    parameter int         DUMMY_CLKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       addr32_mode,
    input  logic       spi_sck,
    input  logic       spi_cs_n,
    input  logic [3:0] spi_io_in,
    output logic [3:0] spi_io_out,
    output logic       spi_io_oe
);

    localparam int PTR_W = $clog2(MEM_BYTES);

    logic             sck_rise;
    logic             sck_fall;
    logic             cs_act;
    logic             cs_start;
    logic [3:0]       io_s;
    phase_t           phase;
    logic [PTR_W-1:0] addr_q;
    logic [PTR_W-1:0] rd_ptr;
    logic             cont_mode;
    logic             wrap_en;
    logic [1:0]       wrap_code;

    qspi_pin_sync #(
        .SYNC_STAGES(2)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_pin (spi_sck),
        .cs_n_pin(spi_cs_n),
        .io_pin  (spi_io_in),
        .sck_rise(sck_rise),
        .sck_fall(sck_fall),
        .cs_act  (cs_act),
        .cs_start(cs_start),
        .io_s    (io_s)
    );

    qspi_cmd_fsm #(
        .PTR_W     (PTR_W),
        .DUMMY_CLKS(DUMMY_CLKS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_act     (cs_act),
        .cs_start   (cs_start),
        .sck_rise   (sck_rise),
        .io_s       (io_s),
        .addr32_mode(addr32_mode),
        .phase      (phase),
        .addr_q     (addr_q),
        .cont_mode  (cont_mode),
        .wrap_en    (wrap_en),
        .wrap_code  (wrap_code)
    );

    qspi_read_path #(
        .MEM_BYTES(MEM_BYTES),
        .FILL     (FILL),
        .PTR_W    (PTR_W)
    ) u_path (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_act   (cs_act),
        .sck_fall (sck_fall),
        .phase    (phase),
        .addr_q   (addr_q),
        .wrap_en  (wrap_en),
        .wrap_code(wrap_code),
        .rd_ptr   (rd_ptr),
        .io_out   (spi_io_out),
        .io_oe    (spi_io_oe)
    );

endmodule

// File: rtl/qspi_read_chk.sv
// Module: qspi_read_chk
// Property checker bound to qspi_read_slave. It observes the output pins,
// the synchronized strobes, the phase and the read pointer.
module qspi_read_chk
    import qspi_rd_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_act,
    input logic             sck_fall,
    input phase_t           phase,
    input logic             cont_mode,
    input logic             wrap_en,
    input logic [1:0]       wrap_code,
    input logic [PTR_W-1:0] rd_ptr,
    input logic [3:0]       spi_io_out,
    input logic             spi_io_oe
);

    logic [PTR_W-1:0] mask_c;

    // Section mask recomputed for the wrap property.
    always_comb mask_c = PTR_W'(wrap_mask(wrap_code));

    assert_release_on_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !spi_io_oe);

    assert_drive_only_in_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        spi_io_oe |-> (phase == PH_DATA));

    assert_out_changes_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_fall |=> $stable(spi_io_out));

    assert_linear_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == PH_DATA && !$stable(rd_ptr) && !wrap_en)
        |-> (rd_ptr == $past(rd_ptr) + 1'b1));

    assert_wrap_in_section_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == PH_DATA && !$stable(rd_ptr) && wrap_en)
        |-> (((rd_ptr ^ $past(rd_ptr)) & ~mask_c) == '0));

    assert_cont_set_by_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cont_mode) |-> ($past(phase) == PH_MODE));

endmodule

bind qspi_read_slave qspi_read_chk #(
    .PTR_W(PTR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_act    (cs_act),
    .sck_fall  (sck_fall),
    .phase     (phase),
    .cont_mode (cont_mode),
    .wrap_en   (wrap_en),
    .wrap_code (wrap_code),
    .rd_ptr    (rd_ptr),
    .spi_io_out(spi_io_out),
    .spi_io_oe (spi_io_oe)
);

// File: tb/qspi_read_slave_tb.sv
module qspi_read_slave_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int NVEC       = 6;

    // Fields: [63:60] skip opcode, [59:56] 32-bit address, [55:52] idle-high clock,
    // [51:48] byte count, [47:40] mode byte, [39:8] address.
    localparam logic [63:0] VEC [NVEC] = '{
        64'h0_0_0_6_00_00000006_00,
        64'h0_0_0_5_00_000000FD_00,
        64'h0_0_1_4_20_00123456_00,
        64'h1_0_0_4_A0_00000080_00,
        64'h1_0_0_4_FF_00000033_00,
        64'h0_1_1_4_00_ABCDEF07_00
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       a32 = 1'b0;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic [3:0] din = 4'h0;
    logic [3:0] dout;
    logic       oe;

    int         n_chk = 0;
    int         n_bad = 0;
    logic       m_wen = 1'b0;
    logic [1:0] m_wcode = 2'b00;

    qspi_read_slave u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr32_mode(a32),
        .spi_sck    (sck),
        .spi_cs_n   (cs_n),
        .spi_io_in  (din),
        .spi_io_out (dout),
        .spi_io_oe  (oe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_byte(input logic [7:0] a);
        return a ^ 8'h5A;
    endfunction

    function automatic logic [7:0] m_next(input logic [7:0] a);
        int len;
        int base;
        len = 8 << m_wcode;
        if (!m_wen) return a + 8'd1;
        base = int'(a) - (int'(a) % len);
        return 8'(base + ((int'(a) % len) + 1) % len);
    endfunction

    task automatic xfer(input logic [3:0] d, output logic [3:0] q, output logic o);
        din = d;
        repeat (HALF) @(negedge clk);
        q = dout;
        o = oe;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic start_cs(input bit m3);
        @(negedge clk);
        sck = m3;
        repeat (3) @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        if (m3) sck = 1'b0;
    endtask

    task automatic end_cs(input bit m3);
        repeat (HALF) @(negedge clk);
        if (m3) sck = 1'b1;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic send_op(input logic [7:0] op);
        logic [3:0] q;
        logic       o;
        for (int i = 7; i >= 0; i--) xfer({3'b000, op[i]}, q, o);
    endtask

    task automatic run_read(input bit skip, input bit a32m, input bit m3, input logic [31:0] addr,
                            input logic [7:0] mode, input int nbytes, input string req);
        logic [3:0] hi;
        logic [3:0] lo;
        logic       o1;
        logic       o2;
        logic [7:0] a;
        a32 = a32m;
        start_cs(m3);
        if (!skip) send_op(8'hEB);
        for (int i = (a32m ? 7 : 5); i >= 0; i--) xfer(addr[i*4 +: 4], hi, o1);
        xfer(mode[7:4], hi, o1);
        xfer(mode[3:0], hi, o1);
        for (int i = 0; i < 4; i++) xfer(4'h0, hi, o1);
        a = addr[7:0];
        for (int b = 0; b < nbytes; b++) begin
            xfer(4'h0, hi, o1);
            xfer(4'h0, lo, o2);
            chk(o1 && o2, "R4 enable during data", int'({o1, o2}), 3);
            chk({hi, lo} == m_byte(a), req, int'({hi, lo}), int'(m_byte(a)));
            a = m_next(a);
        end
        end_cs(m3);
        chk(oe == 1'b0, "R10 enable after deselect", int'(oe), 0);
    endtask

    task automatic set_wrap(input logic [7:0] w);
        logic [3:0] q;
        logic       o;
        start_cs(1'b0);
        send_op(8'h77);
        for (int i = 0; i < 6; i++) xfer(4'h0, q, o);
        xfer(w[7:4], q, o);
        xfer(w[3:0], q, o);
        end_cs(1'b0);
        m_wen   = !w[4];
        m_wcode = w[6:5];
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [3:0] q;
        logic       o;
        logic       seen;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(oe == 1'b0, "R1 enable low after reset", int'(oe), 0);

        // Vector table: linear reads, rollover, continuous-read, 32-bit address, idle-high clock.
        for (int v = 0; v < NVEC; v++) begin
            string req;
            case (v)
                0:       req = "R1 R2 R3 R5 linear from reset";
                1:       req = "R6 rollover at array end";
                2:       req = "R3 R12 nibble order idle-high clock";
                3:       req = "R7 access without opcode";
                4:       req = "R7 continuous-read kept then cleared";
                default: req = "R3 R7 R12 32-bit address after clear";
            endcase
            run_read(VEC[v][60], VEC[v][56], VEC[v][52], VEC[v][39:8], VEC[v][47:40],
                     int'(VEC[v][51:48]), req);
        end

        // Wrap sections of every length, then wrap disabled again.
        set_wrap(8'h00);
        run_read(1'b0, 1'b0, 1'b0, 32'h1D, 8'h00, 6, "R8 R9 wrap 8 bytes");
        set_wrap(8'h20);
        run_read(1'b0, 1'b0, 1'b1, 32'h2F, 8'h00, 3, "R8 R9 wrap 16 bytes");
        set_wrap(8'h40);
        run_read(1'b0, 1'b0, 1'b0, 32'h5E, 8'h00, 3, "R8 R9 wrap 32 bytes");
        set_wrap(8'h60);
        run_read(1'b0, 1'b0, 1'b0, 32'h7E, 8'h00, 4, "R8 R9 wrap 64 bytes");

        // Unknown opcode: no drive, and the 64-byte wrap setting survives it.
        start_cs(1'b0);
        send_op(8'h0B);
        seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            xfer(4'h7, q, o);
            seen = seen | o;
        end
        end_cs(1'b0);
        chk(seen == 1'b0, "R11 unknown opcode ignored", int'(seen), 0);
        run_read(1'b0, 1'b0, 1'b0, 32'hBF, 8'h00, 2, "R11 wrap setting kept");

        set_wrap(8'h70);
        run_read(1'b0, 1'b0, 1'b0, 32'h1E, 8'h00, 4, "R8 wrap disabled by W4");

        // Abort in the address phase with continuous-read on: the state must survive.
        run_read(1'b0, 1'b0, 1'b0, 32'h40, 8'h20, 1, "R7 enter continuous-read");
        start_cs(1'b0);
        xfer(4'h0, q, o);
        xfer(4'h0, q, o);
        end_cs(1'b0);
        chk(oe == 1'b0, "R10 abort in address phase", int'(oe), 0);
        run_read(1'b1, 1'b0, 1'b0, 32'h91, 8'h00, 2, "R7 R10 state kept across abort");

        // Abort in the middle of a data byte.
        run_read(1'b0, 1'b0, 1'b0, 32'h10, 8'h00, 1, "R5 before data abort");
        start_cs(1'b0);
        send_op(8'hEB);
        for (int i = 0; i < 12; i++) xfer(4'h0, q, o);
        xfer(4'h0, q, o);
        chk(o == 1'b1, "R4 drive before abort", int'(o), 1);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(oe == 1'b0, "R10 release within 3 clocks", int'(oe), 0);
        repeat (8) @(negedge clk);
        run_read(1'b0, 1'b0, 1'b0, 32'hFF, 8'h00, 2, "R6 R10 read after data abort");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule